// File: doc/BRIEF.md
# Sample Voice Address Generator

This block walks one playback voice through a waveform held in sample memory. A rising edge on the key input starts the voice at the start of the waveform. After that, each sample tick adds a pitch-dependent step to a fixed-point position. Each new position becomes a byte address with a fetch strobe, so a downstream decoder knows which byte to read and, for 4-bit compressed data, which nibble of that byte to use.

When the position reaches the end marker, the voice either stops or jumps back to the loop start. Which one happens depends on the loop enable and the sample format. A status word gives a fixed code for playing and another for stopped. A readback port shows the integer position as it stands after each sample tick. Sample decoding, envelopes, filtering and mixing belong to other blocks.

Top module: `voice_addr_gen`

## Requirements
- R1: After reset, `playing` is 0, `statusWord` is 0x4000, `fetchStb` is 0 and `posReadback` is 0.
- R2: A rising edge of `keyState` sets the position and fraction to zero and sets `playing`. In the following cycle, `fetchStb` is 1 and `memAddr` equals the start address. A key-on edge takes priority over a sample tick in the same cycle.
- R3: On each `sampleTick` while playing, the position advances by (2048 + fraction field) × 2^octave / 2048 samples. The fraction field is `pitchWord[10:0]`. The octave is `pitchWord[15:11]`, read as two's complement, so 5'b11111 means -1.
- R4: The start address is {`startHi`, `startLo`}. `memAddr` is start + 2×position for format 0 (16-bit), start + position for format 1 (8-bit), and start + position/2 for formats 2 and 3 (4-bit). For formats 2 and 3, `nibbleSel` equals the position's least significant bit; for formats 0 and 1 it is 0.
- R5: When looping is not in effect and a step reaches or passes `loopEnd`, the voice stops. The position is held at `loopEnd` and no fetch is issued for that step. Later ticks neither move it nor fetch, until the next key-on.
- R6: When looping is in effect and a step reaches or passes `loopEnd`, the position becomes `loopStart` plus the amount of overshoot. The fractional part is kept.
- R7: Format 3 loops even when `loopEn` is 0.
- R8: A falling edge of `keyState` does not stop a voice. A looping voice stops at the first end crossing after looping is withdrawn.
- R9: `statusWord` reads 0x7FFF while playing and 0x4000 while stopped. A wrap at the end marker shows 0x4000 for exactly one cycle, then 0x7FFF again.
- R10: `posReadback` loads the integer position that results from the step, only on a cycle with `sampleTick`. A key-on without a tick leaves it unchanged.
- R11: `fetchStb` is a one-cycle pulse following each key-on or each tick that advances a playing voice. It is never high while stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| keyState | input | 1 | Key level; a rising edge starts the voice |
| loopEn | input | 1 | Loop enable |
| fmtSel | input | 2 | Sample format: 0 16-bit, 1 8-bit, 2 4-bit, 3 looping 4-bit |
| startHi | input | 7 | Start address, upper bits |
| startLo | input | 16 | Start address, lower bits |
| loopStart | input | 16 | Loop start sample index |
| loopEnd | input | 16 | Loop end sample index, or sample length |
| pitchWord | input | 16 | Octave [15:11] and pitch fraction [10:0] |
| sampleTick | input | 1 | One pulse per output sample period |
| memAddr | output | 23 | Byte address to fetch |
| fetchStb | output | 1 | Fetch strobe for `memAddr` |
| nibbleSel | output | 1 | Nibble to use for 4-bit data |
| posReadback | output | 16 | Integer position captured at the last tick |
| statusWord | output | 16 | 0x7FFF playing, 0x4000 stopped or wrapping |
| playing | output | 1 | Voice active |

## Verification
The assertions assume the following about the inputs:
- `fmtSel`, `loopEn` and the address fields do not change in the cycle before a fetch whose nibble meaning is being checked.
- `loopEnd` is greater than `loopStart`, as R6 needs for a meaningful wrap.

The directed tests change formats and loop settings only between scenarios, with `sampleTick` low. Every scenario programs loop points that are ordered this way. Step sizes stay below the loop length, so every wrap needs a single subtraction.

// File: rtl/vag_pkg.sv
package vag_pkg;
  localparam logic [1:0] FMT_PCM16     = 2'd0;
  localparam logic [1:0] FMT_PCM8      = 2'd1;
  localparam logic [1:0] FMT_NIB       = 2'd2;
  localparam logic [1:0] FMT_NIB_LOOP  = 2'd3;

  localparam logic [15:0] STAT_RUN  = 16'h7FFF;
  localparam logic [15:0] STAT_IDLE = 16'h4000;

  typedef struct packed {
    logic clearPos;
    logic step;
    logic wrap;
    logic stop;
    logic capture;
  } vagStrobes_t;
endpackage

// File: rtl/vag_ctrl.sv
module vag_ctrl
  import vag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        keyState,
  input  logic        sampleTick,
  input  logic        loopEn,
  input  logic [1:0]  fmtSel,
  input  logic        endHit,
  output vagStrobes_t strobes,
  output logic        playing,
  output logic [15:0] statusWord
);
  logic keyPrev;
  logic wrapFlag;
  logic keyRise;
  logic loopEff;

  assign keyRise = keyState & ~keyPrev;
  assign loopEff = loopEn | (fmtSel == FMT_NIB_LOOP);

  always_comb begin
    strobes.clearPos = keyRise;
    strobes.step     = sampleTick & playing & ~keyRise;
    strobes.wrap     = strobes.step & endHit & loopEff;
    strobes.stop     = strobes.step & endHit & ~loopEff;
    strobes.capture  = sampleTick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyPrev  <= 1'b0;
      playing  <= 1'b0;
      wrapFlag <= 1'b0;
    end else begin
      keyPrev  <= keyState;
      wrapFlag <= strobes.wrap;
      if (strobes.clearPos)  playing <= 1'b1;
      else if (strobes.stop) playing <= 1'b0;
    end
  end

  assign statusWord = (playing && !wrapFlag) ? STAT_RUN : STAT_IDLE;
endmodule

// File: rtl/vag_datapath.sv
module vag_datapath
  import vag_pkg::*;
#(
  parameter int HiW   = 7,
  parameter int PosW  = 16,
  parameter int FracW = 11,
  parameter int OctW  = 5,
  localparam int AddrW  = HiW + PosW,
  localparam int PitchW = OctW + FracW
) (
  input  logic              clk,
  input  logic              rstN,
  input  vagStrobes_t       strobes,
  input  logic [1:0]        fmtSel,
  input  logic [HiW-1:0]    startHi,
  input  logic [PosW-1:0]   startLo,
  input  logic [PosW-1:0]   loopStart,
  input  logic [PosW-1:0]   loopEnd,
  input  logic [PitchW-1:0] pitchWord,
  output logic              endHit,
  output logic [AddrW-1:0]  memAddr,
  output logic              fetchStb,
  output logic              nibbleSel,
  output logic [PosW-1:0]   posReadback
);
  localparam int AccW = PosW + FracW;
  localparam int IncW = FracW + 2 ** (OctW - 1);
  localparam int MaxW = (AccW > IncW) ? AccW : IncW;
  localparam int SumW = MaxW + 1;
  localparam int IntW = SumW - FracW;

  logic [PosW-1:0]  posQ, posNext, wrapPos;
  logic [FracW-1:0] fracQ, fracNext, newFrac;
  logic [OctW-1:0]  octField, negAmt;
  logic [FracW-1:0] fnsField;
  logic [IncW-1:0]  baseInc, incVal;
  logic [SumW-1:0]  sum;
  logic [IntW-1:0]  newInt, overshoot, wrapRaw;
  logic [AddrW-1:0] startAddr, offset;
  logic             fetchNext;

  assign octField = pitchWord[PitchW-1 -: OctW];
  assign fnsField = pitchWord[FracW-1:0];
  assign negAmt   = ~octField + 1'b1;
  assign baseInc  = IncW'({1'b1, fnsField});

  always_comb begin
    if (!octField[OctW-1]) incVal = baseInc << octField;
    else                   incVal = baseInc >> negAmt;
  end

  assign sum     = SumW'({posQ, fracQ}) + SumW'(incVal);
  assign newInt  = sum[SumW-1:FracW];
  assign newFrac = sum[FracW-1:0];
  assign endHit  = newInt >= IntW'(loopEnd);

  assign overshoot = newInt - IntW'(loopEnd);
  assign wrapRaw   = IntW'(loopStart) + overshoot;
  assign wrapPos   = (wrapRaw >= IntW'(loopEnd)) ? loopStart : wrapRaw[PosW-1:0];

  always_comb begin
    posNext  = posQ;
    fracNext = fracQ;
    if (strobes.clearPos) begin
      posNext  = '0;
      fracNext = '0;
    end else if (strobes.stop) begin
      posNext  = loopEnd;
      fracNext = '0;
    end else if (strobes.wrap) begin
      posNext  = wrapPos;
      fracNext = newFrac;
    end else if (strobes.step) begin
      posNext  = newInt[PosW-1:0];
      fracNext = newFrac;
    end
  end

  assign startAddr = {startHi, startLo};

  always_comb begin
    case (fmtSel)
      FMT_PCM16: offset = AddrW'({posNext, 1'b0});
      FMT_PCM8:  offset = AddrW'(posNext);
      default:   offset = AddrW'(posNext >> 1);
    endcase
  end

  assign fetchNext = strobes.clearPos | (strobes.step & ~strobes.stop);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posQ        <= '0;
      fracQ       <= '0;
      memAddr     <= '0;
      fetchStb    <= 1'b0;
      nibbleSel   <= 1'b0;
      posReadback <= '0;
    end else begin
      posQ     <= posNext;
      fracQ    <= fracNext;
      fetchStb <= fetchNext;
      if (fetchNext) begin
        memAddr   <= startAddr + offset;
        nibbleSel <= fmtSel[1] & posNext[0];
      end
      if (strobes.capture) posReadback <= posNext;
    end
  end
endmodule

// File: rtl/voice_addr_gen.sv
module voice_addr_gen
  import vag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        keyState,
  input  logic        loopEn,
  input  logic [1:0]  fmtSel,
  input  logic [6:0]  startHi,
  input  logic [15:0] startLo,
  input  logic [15:0] loopStart,
  input  logic [15:0] loopEnd,
  input  logic [15:0] pitchWord,
  input  logic        sampleTick,
  output logic [22:0] memAddr,
  output logic        fetchStb,
  output logic        nibbleSel,
  output logic [15:0] posReadback,
  output logic [15:0] statusWord,
  output logic        playing
);
  vagStrobes_t strobes;
  logic        endHit;

  vag_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .keyState   (keyState),
    .sampleTick (sampleTick),
    .loopEn     (loopEn),
    .fmtSel     (fmtSel),
    .endHit     (endHit),
    .strobes    (strobes),
    .playing    (playing),
    .statusWord (statusWord)
  );

  vag_datapath #(
    .HiW   (7),
    .PosW  (16),
    .FracW (11),
    .OctW  (5)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .fmtSel      (fmtSel),
    .startHi     (startHi),
    .startLo     (startLo),
    .loopStart   (loopStart),
    .loopEnd     (loopEnd),
    .pitchWord   (pitchWord),
    .endHit      (endHit),
    .memAddr     (memAddr),
    .fetchStb    (fetchStb),
    .nibbleSel   (nibbleSel),
    .posReadback (posReadback)
  );
endmodule

// File: rtl/vag_checker.sv
module vag_checker
  import vag_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        keyState,
  input logic        loopEn,
  input logic [1:0]  fmtSel,
  input logic        sampleTick,
  input logic        fetchStb,
  input logic        nibbleSel,
  input logic [15:0] statusWord,
  input logic        playing
);
  assert_keyon_starts_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(keyState) |=> (playing && fetchStb));

  assert_byte_formats_no_nibble_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fetchStb && $stable(fmtSel) && !fmtSel[1]) |-> !nibbleSel);

  assert_stopped_stays_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!playing && !$rose(keyState)) |=> !playing);

  assert_loop_keeps_running_R7: assert property (@(posedge clk) disable iff (!rstN)
    (playing && (loopEn || fmtSel == FMT_NIB_LOOP) && !$rose(keyState)) |=> playing);

  assert_status_legal_R9: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord == STAT_RUN) || (statusWord == STAT_IDLE));

  assert_idle_code_R9: assert property (@(posedge clk) disable iff (!rstN)
    !playing |-> (statusWord == STAT_IDLE));

  assert_fetch_needs_play_R11: assert property (@(posedge clk) disable iff (!rstN)
    fetchStb |-> playing);

  assert_fetch_has_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleTick && !$rose(keyState)) |=> !fetchStb);
endmodule

bind voice_addr_gen vag_checker vag_checker_i (
  .clk        (clk),
  .rstN       (rstN),
  .keyState   (keyState),
  .loopEn     (loopEn),
  .fmtSel     (fmtSel),
  .sampleTick (sampleTick),
  .fetchStb   (fetchStb),
  .nibbleSel  (nibbleSel),
  .statusWord (statusWord),
  .playing    (playing)
);

// File: tb/voice_addr_gen_tb_top.sv
`timescale 1ns/1ps
module voice_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        keyState = 1'b0;
  logic        loopEn = 1'b0;
  logic [1:0]  fmtSel = 2'd0;
  logic [6:0]  startHi = '0;
  logic [15:0] startLo = '0;
  logic [15:0] loopStart = '0;
  logic [15:0] loopEnd = 16'd1;
  logic [15:0] pitchWord = '0;
  logic        sampleTick = 1'b0;
  logic [22:0] memAddr;
  logic        fetchStb;
  logic        nibbleSel;
  logic [15:0] posReadback;
  logic [15:0] statusWord;
  logic        playing;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  voice_addr_gen dut_i (
    .clk(clk), .rstN(rstN), .keyState(keyState), .loopEn(loopEn),
    .fmtSel(fmtSel), .startHi(startHi), .startLo(startLo),
    .loopStart(loopStart), .loopEnd(loopEnd), .pitchWord(pitchWord),
    .sampleTick(sampleTick), .memAddr(memAddr), .fetchStb(fetchStb),
    .nibbleSel(nibbleSel), .posReadback(posReadback),
    .statusWord(statusWord), .playing(playing)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) sampleTick = 1'b1;
    @(negedge clk) sampleTick = 1'b0;
  endtask

  task automatic keyOn();
    @(negedge clk) keyState = 1'b0;
    @(negedge clk) keyState = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "playing", 32'(playing), 32'd0);
    chk("R1", "status", 32'(statusWord), 32'h4000);
    chk("R1", "fetch", 32'(fetchStb), 32'd0);
    chk("R1", "readback", 32'(posReadback), 32'd0);
  endtask

  task automatic t_pcm16_stop();
    fmtSel = 2'd0; loopEn = 1'b0; startHi = 7'h00; startLo = 16'h0100;
    loopStart = 16'd0; loopEnd = 16'd4; pitchWord = 16'h0000;
    keyOn();
    chk("R2", "playing after key-on", 32'(playing), 32'd1);
    chk("R2", "fetch after key-on", 32'(fetchStb), 32'd1);
    chk("R2", "addr at start", 32'(memAddr), 32'h100);
    chk("R9", "status playing", 32'(statusWord), 32'h7FFF);
    for (int i = 1; i <= 3; i++) begin
      tick();
      chk("R4", "pcm16 addr", 32'(memAddr), 32'h100 + 32'(2 * i));
      chk("R10", "readback", 32'(posReadback), 32'(i));
      chk("R11", "fetch per tick", 32'(fetchStb), 32'd1);
    end
    @(negedge clk);
    chk("R11", "fetch one cycle", 32'(fetchStb), 32'd0);
    tick();
    chk("R5", "stopped at end", 32'(playing), 32'd0);
    chk("R5", "no fetch at stop", 32'(fetchStb), 32'd0);
    chk("R5", "held at end", 32'(posReadback), 32'd4);
    chk("R9", "status stopped", 32'(statusWord), 32'h4000);
    tick();
    chk("R5", "tick while stopped no fetch", 32'(fetchStb), 32'd0);
    chk("R5", "tick while stopped keeps pos", 32'(posReadback), 32'd4);
  endtask

  task automatic t_pcm8_halfrate();
    fmtSel = 2'd1; startHi = 7'h01; startLo = 16'h0010;
    loopEnd = 16'd100; pitchWord = {5'b11111, 11'd0};
    keyOn();
    chk("R4", "pcm8 start", 32'(memAddr), 32'h010010);
    for (int i = 1; i <= 4; i++) begin
      tick();
      chk("R3", "half rate pos", 32'(posReadback), 32'(i / 2));
      chk("R4", "pcm8 addr", 32'(memAddr), 32'h010010 + 32'(i / 2));
      chk("R4", "pcm8 nibble", 32'(nibbleSel), 32'd0);
    end
  endtask

  task automatic t_nib_loop();
    fmtSel = 2'd2; loopEn = 1'b1; startHi = 7'h00; startLo = 16'h0200;
    loopStart = 16'd2; loopEnd = 16'd5; pitchWord = {5'd1, 11'd0};
    keyOn();
    chk("R4", "nibble start addr", 32'(memAddr), 32'h200);
    tick();
    chk("R3", "double rate", 32'(posReadback), 32'd2);
    chk("R4", "nibble addr pos2", 32'(memAddr), 32'h201);
    tick();
    chk("R4", "nibble addr pos4", 32'(memAddr), 32'h202);
    tick();
    chk("R6", "wrap with overshoot", 32'(posReadback), 32'd3);
    chk("R4", "wrap addr", 32'(memAddr), 32'h201);
    chk("R4", "odd nibble", 32'(nibbleSel), 32'd1);
    chk("R9", "wrap status", 32'(statusWord), 32'h4000);
    chk("R6", "still playing", 32'(playing), 32'd1);
    @(negedge clk);
    chk("R9", "status back to run", 32'(statusWord), 32'h7FFF);
    keyState = 1'b0;
    tick();
    chk("R8", "key-off keeps looping", 32'(playing), 32'd1);
    chk("R6", "second wrap", 32'(posReadback), 32'd2);
    loopEn = 1'b0;
    tick();
    chk("R8", "runs to end", 32'(posReadback), 32'd4);
    tick();
    chk("R8", "stops once loop off", 32'(playing), 32'd0);
    chk("R5", "held at end", 32'(posReadback), 32'd5);
  endtask

  task automatic t_fmt3_loop();
    fmtSel = 2'd3; loopEn = 1'b0; startHi = 7'h00; startLo = 16'h0300;
    loopStart = 16'd0; loopEnd = 16'd2; pitchWord = {5'd0, 11'd1024};
    keyOn();
    tick();
    chk("R3", "1.5 step", 32'(posReadback), 32'd1);
    chk("R4", "fmt3 nibble", 32'(nibbleSel), 32'd1);
    chk("R4", "fmt3 addr", 32'(memAddr), 32'h300);
    tick();
    chk("R7", "fmt3 loops without enable", 32'(playing), 32'd1);
    chk("R7", "fmt3 wrap pos", 32'(posReadback), 32'd1);
    chk("R9", "fmt3 wrap status", 32'(statusWord), 32'h4000);
  endtask

  task automatic t_restart();
    fmtSel = 2'd1; loopEn = 1'b0; startHi = 7'h00; startLo = 16'h0040;
    loopEnd = 16'd100; pitchWord = 16'h0000;
    keyOn();
    tick(); tick(); tick();
    chk("R10", "readback three", 32'(posReadback), 32'd3);
    keyOn();
    chk("R10", "key-on alone keeps readback", 32'(posReadback), 32'd3);
    chk("R2", "restart addr", 32'(memAddr), 32'h40);
    tick();
    chk("R2", "restart from zero", 32'(posReadback), 32'd1);
    @(negedge clk) keyState = 1'b0;
    @(negedge clk) begin keyState = 1'b1; sampleTick = 1'b1; end
    @(negedge clk) sampleTick = 1'b0;
    chk("R2", "key-on beats tick", 32'(posReadback), 32'd0);
    chk("R2", "key-on beats tick addr", 32'(memAddr), 32'h40);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_pcm16_stop();
    t_pcm8_halfrate();
    t_nib_loop();
    t_fmt3_loop();
    t_restart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule